// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel, its video source and its LVDS serializer up and down in a fixed, safe order. On an enable request it turns on panel power with the backlight held off. It waits out the supply ramp and a settling time, then enables the video source while forcing black pixels. Next it releases the serializer from standby and keeps black on screen long enough for the serializer's clock loop to lock. After that it switches to real image data, and only then does it light the backlight. When the request is withdrawn it reverses the order. The backlight goes off first and its minimum turn-off time is allowed. Black is then forced for a number of frame-start pulses, the serializer returns to standby, a short guard time passes, video is disabled, and panel power is removed last.

Every timed wait is given in nanoseconds together with the clock period, and each is turned into a whole number of clock cycles that never falls short of the minimum. The black hold on power-down is counted in frames rather than time. If the request is withdrawn part way through power-up, the block moves straight to the power-down step that matches the outputs already on. A raised request during power-down is held off until the panel is fully off. The outputs are decoded from a single state register. A request sampled on a clock edge changes the outputs on that same edge.

Top module: `lcd_pwr_seq`

## Requirements
- R1: A synchronous reset puts the block in the fully-off state. From the edge that samples reset, panel_pwr_en, video_en, black_sel, ser_shdn, bl_en, busy and panel_on are all 0. With en_req low, the fully-off state persists.
- R2: On power-up the output vector {panel_pwr_en, video_en, black_sel, ser_shdn, bl_en, busy, panel_on} steps through 1000010, then 1110010, then 1111010, then 1101010, and then 1101101, with nothing else in between. Panel power rises on the edge that samples en_req high. The video-with-black step lasts max(1, ceil(VID_LEAD_NS/CLK_NS)) cycles.
- R3: The supply ramp lasts max(1, ceil(RAMP_NS/CLK_NS)) cycles and the settling wait lasts max(1, ceil(SETTLE_NS/CLK_NS)) cycles. Both show vector 1000010, so a zero settling time adds exactly one cycle.
- R4: After the serializer is released, black lasts floor(LOCK_NS/CLK_NS)+1 cycles, which is strictly more than LOCK_NS. Image data without backlight then lasts max(1, ceil(BL_LEAD_NS/CLK_NS)) cycles before bl_en rises.
- R5: busy is 1 in every state except fully-off and fully-on. panel_on is 1 only in fully-on, where the vector is 1101101.
- R6: When en_req is sampled low in fully-on, bl_en falls on that edge and the vector 1101010 lasts max(1, ceil(BL_OFF_NS/CLK_NS)) cycles before black is forced.
- R7: During the power-down black hold (vector 1111010), ser_shdn drops on the edge that samples the FRAMES-th frame_start pulse seen inside the hold. Pulses that arrive before the hold starts are not counted.
- R8: After ser_shdn falls, video stays on with black (vector 1110010) for max(1, ceil(SHDN_NS/CLK_NS)) cycles. Video and black then drop together, and panel power alone (1000010) lasts max(1, ceil(VID_OFF_NS/CLK_NS)) cycles before fully-off.
- R9: If en_req goes low during power-up, the next edge moves the block as follows. From the ramp or settling step it goes to the panel-only step. From the video-with-black step it goes to the serializer guard step. From the lock or image step it goes to the black hold. The power-down then completes as in R7 and R8.
- R10: en_req raised during power-down does not alter the power-down sequence. The block reaches fully-off, spends exactly one cycle there, and then restarts power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Level request: 1 = panel on, 0 = panel off |
| frame_start | input | 1 | One-cycle pulse at each frame start from video timing |
| panel_pwr_en | output | 1 | Panel supply enable |
| video_en | output | 1 | Video source output enable |
| black_sel | output | 1 | 1 = video source sends black pixels |
| ser_shdn | output | 1 | Serializer shutdown control; with default polarity 0 = standby, 1 = running |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | Sequence in progress |
| panel_on | output | 1 | Panel fully on |

## Verification
The bench builds the block with a 4 ns clock and short waits: 30 ns, 0 ns, 5 ns, 40 ns, 9 ns, 21 ns, 250 ns and 3 ns, with a three-frame hold. Every wait then maps to a few cycles, and most of them exercise the round-up rule: 30 ns becomes 8 cycles, 0 ns becomes 1, and 250 ns becomes 63. The lock hold gives 11 cycles, which shows the strictly-longer rule at an exact multiple. These short values put full sequences, every abort entry point, a request re-raised during power-down and frame pulses at two different spacings within a few thousand cycles.

// File: rtl/lcd_pwr_seq_pkg.sv
`timescale 1ns/1ps
package lcd_pwr_seq_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_RAMP,
      ST_SETTLE,
      ST_VID_BLK,
      ST_LOCK,
      ST_IMG_LEAD,
      ST_ON,
      ST_BL_OFF,
      ST_FRM_HOLD,
      ST_SHDN_WAIT,
      ST_VID_DROP
   } seq_st_e;

   typedef struct packed {
      logic pwr;
      logic vid;
      logic blk;
      logic run;
      logic bl;
   } seq_out_t;

   // cycles covering at least ns, never fewer than one
   function automatic int cyc_ceil(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   // cycles covering strictly more than ns
   function automatic int cyc_over(input int ns, input int clk_ns);
      return (ns / clk_ns) + 1;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lcd_pwr_wait_timer.sv
`timescale 1ns/1ps
module lcd_pwr_wait_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [TW-1:0] lim,
   output logic          done
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= lim;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/lcd_pwr_frame_cnt.sv
`timescale 1ns/1ps
module lcd_pwr_frame_cnt #(
   parameter int FRAMES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic frame_start,
   output logic done
);

   localparam int FW = $clog2(FRAMES + 1);
   localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

   logic [FW-1:0] fcnt;

   always_ff @(posedge clk) begin
      if (rst || !arm) begin
         fcnt <= '0;
      end else if (frame_start && fcnt != LAST) begin
         fcnt <= fcnt + 1'b1;
      end
   end

   assign done = arm && frame_start && (fcnt == LAST);

endmodule

// File: rtl/lcd_pwr_out_dec.sv
`timescale 1ns/1ps
module lcd_pwr_out_dec
   import lcd_pwr_seq_pkg::*;
(
   input  seq_st_e  st,
   output seq_out_t o,
   output logic     busy,
   output logic     on
);

   always_comb begin
      o    = '0;
      busy = 1'b1;
      on   = 1'b0;
      unique case (st)
         ST_OFF:       busy = 1'b0;
         ST_RAMP,
         ST_SETTLE,
         ST_VID_DROP:  o.pwr = 1'b1;
         ST_VID_BLK,
         ST_SHDN_WAIT: begin
            o.pwr = 1'b1; o.vid = 1'b1; o.blk = 1'b1;
         end
         ST_LOCK,
         ST_FRM_HOLD: begin
            o.pwr = 1'b1; o.vid = 1'b1; o.blk = 1'b1; o.run = 1'b1;
         end
         ST_IMG_LEAD,
         ST_BL_OFF: begin
            o.pwr = 1'b1; o.vid = 1'b1; o.run = 1'b1;
         end
         ST_ON: begin
            o.pwr = 1'b1; o.vid = 1'b1; o.run = 1'b1; o.bl = 1'b1;
            busy  = 1'b0; on = 1'b1;
         end
         default: busy = 1'b0;
      endcase
   end

endmodule

// File: rtl/lcd_pwr_seq.sv
`timescale 1ns/1ps
module lcd_pwr_seq
   import lcd_pwr_seq_pkg::*;
#(
   parameter int CLK_NS      = 4,
   parameter int RAMP_NS     = 10_000_000,
   parameter int SETTLE_NS   = 0,
   parameter int VID_LEAD_NS = 1_000,
   parameter int LOCK_NS     = 1_000_000,
   parameter int BL_LEAD_NS  = 1_000,
   parameter int BL_OFF_NS   = 10_000_000,
   parameter int SHDN_NS     = 250,
   parameter int VID_OFF_NS  = 1_000,
   parameter int FRAMES      = 3,
   parameter bit SHDN_ACT_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en_req,
   input  logic frame_start,
   output logic panel_pwr_en,
   output logic video_en,
   output logic black_sel,
   output logic ser_shdn,
   output logic bl_en,
   output logic busy,
   output logic panel_on
);

   localparam int C_RAMP   = cyc_ceil(RAMP_NS, CLK_NS);
   localparam int C_SETTLE = cyc_ceil(SETTLE_NS, CLK_NS);
   localparam int C_VLEAD  = cyc_ceil(VID_LEAD_NS, CLK_NS);
   localparam int C_LOCK   = cyc_over(LOCK_NS, CLK_NS);
   localparam int C_BLLEAD = cyc_ceil(BL_LEAD_NS, CLK_NS);
   localparam int C_BLOFF  = cyc_ceil(BL_OFF_NS, CLK_NS);
   localparam int C_SHDN   = cyc_ceil(SHDN_NS, CLK_NS);
   localparam int C_VOFF   = cyc_ceil(VID_OFF_NS, CLK_NS);
   localparam int C_MAX    = max2(max2(max2(C_RAMP, C_SETTLE), max2(C_VLEAD, C_LOCK)),
                                  max2(max2(C_BLLEAD, C_BLOFF), max2(C_SHDN, C_VOFF)));
   localparam int TW       = (C_MAX > 1) ? $clog2(C_MAX) : 1;

   if (CLK_NS < 1) begin : g_bad_clk
      $error("lcd_pwr_seq: CLK_NS must be at least 1");
   end
   if (FRAMES < 3) begin : g_bad_frames
      $error("lcd_pwr_seq: FRAMES must be at least 3");
   end
   if (RAMP_NS < 0 || SETTLE_NS < 0 || SHDN_NS < 0 || LOCK_NS < 0) begin : g_bad_time
      $error("lcd_pwr_seq: wait times must not be negative");
   end

   seq_st_e       st, nxt;
   logic [TW-1:0] lim;
   logic          tload, tdone, fdone;
   seq_out_t      o;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_OFF:       if (en_req) nxt = ST_RAMP;
         ST_RAMP:      if (!en_req) nxt = ST_VID_DROP;  else if (tdone) nxt = ST_SETTLE;
         ST_SETTLE:    if (!en_req) nxt = ST_VID_DROP;  else if (tdone) nxt = ST_VID_BLK;
         ST_VID_BLK:   if (!en_req) nxt = ST_SHDN_WAIT; else if (tdone) nxt = ST_LOCK;
         ST_LOCK:      if (!en_req) nxt = ST_FRM_HOLD;  else if (tdone) nxt = ST_IMG_LEAD;
         ST_IMG_LEAD:  if (!en_req) nxt = ST_FRM_HOLD;  else if (tdone) nxt = ST_ON;
         ST_ON:        if (!en_req) nxt = ST_BL_OFF;
         ST_BL_OFF:    if (tdone) nxt = ST_FRM_HOLD;
         ST_FRM_HOLD:  if (fdone) nxt = ST_SHDN_WAIT;
         ST_SHDN_WAIT: if (tdone) nxt = ST_VID_DROP;
         ST_VID_DROP:  if (tdone) nxt = ST_OFF;
         default:      nxt = ST_OFF;
      endcase
   end

   always_comb begin
      unique case (nxt)
         ST_RAMP:      lim = TW'(C_RAMP - 1);
         ST_SETTLE:    lim = TW'(C_SETTLE - 1);
         ST_VID_BLK:   lim = TW'(C_VLEAD - 1);
         ST_LOCK:      lim = TW'(C_LOCK - 1);
         ST_IMG_LEAD:  lim = TW'(C_BLLEAD - 1);
         ST_BL_OFF:    lim = TW'(C_BLOFF - 1);
         ST_SHDN_WAIT: lim = TW'(C_SHDN - 1);
         ST_VID_DROP:  lim = TW'(C_VOFF - 1);
         default:      lim = '0;
      endcase
   end

   assign tload = (nxt != st);

   always_ff @(posedge clk) begin
      if (rst) st <= ST_OFF;
      else     st <= nxt;
   end

   lcd_pwr_wait_timer #(.TW(TW)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .load (tload),
      .lim  (lim),
      .done (tdone)
   );

   lcd_pwr_frame_cnt #(.FRAMES(FRAMES)) u_frm (
      .clk         (clk),
      .rst         (rst),
      .arm         (st == ST_FRM_HOLD),
      .frame_start (frame_start),
      .done        (fdone)
   );

   lcd_pwr_out_dec u_dec (
      .st   (st),
      .o    (o),
      .busy (busy),
      .on   (panel_on)
   );

   assign panel_pwr_en = o.pwr;
   assign video_en     = o.vid;
   assign black_sel    = o.blk;
   assign bl_en        = o.bl;

   if (SHDN_ACT_LOW) begin : g_shdn_lo
      assign ser_shdn = o.run;
   end else begin : g_shdn_hi
      assign ser_shdn = ~o.run;
   end

   // R2: video only with panel power
   a_r2_vid_needs_pwr: assert property (@(posedge clk) disable iff (rst)
      video_en |-> panel_pwr_en);
   // R2: serializer running only while video is enabled
   a_r2_run_needs_vid: assert property (@(posedge clk) disable iff (rst)
      o.run |-> video_en);
   // R4: serializer leaves standby only while black is forced
   a_r4_release_in_black: assert property (@(posedge clk) disable iff (rst)
      $rose(o.run) |-> black_sel);
   // R4: backlight only with running serializer and image data
   a_r4_bl_on_image: assert property (@(posedge clk) disable iff (rst)
      bl_en |-> (o.run && !black_sel && video_en));
   // R6: black forced only after backlight already off
   a_r6_bl_first: assert property (@(posedge clk) disable iff (rst)
      $rose(black_sel) |-> (!bl_en && $past(!bl_en)));
   // R7: standby entered only under black data
   a_r7_shdn_in_black: assert property (@(posedge clk) disable iff (rst)
      $fell(o.run) |-> black_sel);
   // R8: video disabled only after serializer standby
   a_r8_vid_after_shdn: assert property (@(posedge clk) disable iff (rst)
      $fell(video_en) |-> (!o.run && $past(!o.run)));
   // R8: panel power removed only after video is off
   a_r8_pwr_last: assert property (@(posedge clk) disable iff (rst)
      $fell(panel_pwr_en) |-> $past(!video_en));
   // R5: busy and fully-on are exclusive
   a_r5_status_excl: assert property (@(posedge clk) disable iff (rst)
      !(busy && panel_on));

endmodule

// File: tb/sim_lcd_pwr_seq.sv
`timescale 1ns/1ps
module sim_lcd_pwr_seq;

   logic clk = 1'b0;
   logic rst, en_req, frame_start;
   logic panel_pwr_en, video_en, black_sel, ser_shdn, bl_en, busy, panel_on;

   always #2 clk = ~clk;

   lcd_pwr_seq #(
      .CLK_NS(4), .RAMP_NS(30), .SETTLE_NS(0), .VID_LEAD_NS(5), .LOCK_NS(40),
      .BL_LEAD_NS(9), .BL_OFF_NS(21), .SHDN_NS(250), .VID_OFF_NS(3), .FRAMES(3)
   ) u0 (
      .clk(clk), .rst(rst), .en_req(en_req), .frame_start(frame_start),
      .panel_pwr_en(panel_pwr_en), .video_en(video_en), .black_sel(black_sel),
      .ser_shdn(ser_shdn), .bl_en(bl_en), .busy(busy), .panel_on(panel_on)
   );

   wire [6:0] vec = {panel_pwr_en, video_en, black_sel, ser_shdn, bl_en, busy, panel_on};

   localparam logic [6:0] V_OFF  = 7'b0000000;
   localparam logic [6:0] V_PWR  = 7'b1000010;
   localparam logic [6:0] V_VBLK = 7'b1110010;
   localparam logic [6:0] V_LOCK = 7'b1111010;
   localparam logic [6:0] V_IMG  = 7'b1101010;
   localparam logic [6:0] V_ON   = 7'b1101101;

   int tests = 0;
   int fails = 0;
   bit mon_go = 1'b0;
   bit finished = 1'b0;

   logic [6:0] q_vec[$];
   int         q_len[$];
   string      q_tag[$];

   logic [6:0] last_v;
   int         seg_len;

   task automatic expect_seg(input logic [6:0] v, input int n, input string tag);
      q_vec.push_back(v);
      q_len.push_back(n);
      q_tag.push_back(tag);
   endtask

   task automatic expect_up();
      expect_seg(V_PWR,  9,  "R3");
      expect_seg(V_VBLK, 2,  "R2");
      expect_seg(V_LOCK, 11, "R4");
      expect_seg(V_IMG,  3,  "R4");
      expect_seg(V_ON,   0,  "R5");
   endtask

   task automatic close_seg(input logic [6:0] v, input int n);
      logic [6:0] ev;
      int         el;
      string      et;
      tests++;
      if (q_vec.size() == 0) begin
         fails++;
         $display("FAIL R2 unexpected segment vec=%b len=%0d expected none", v, n);
         return;
      end
      ev = q_vec.pop_front();
      el = q_len.pop_front();
      et = q_tag.pop_front();
      if (v !== ev || (el != 0 && n != el)) begin
         fails++;
         $display("FAIL %s vec=%b len=%0d expected vec=%b len=%0d", et, v, n, ev, el);
      end
   endtask

   task automatic check_now(input logic [6:0] exp_v, input string tag);
      tests++;
      if (vec !== exp_v) begin
         fails++;
         $display("FAIL %s vec=%b expected %b", tag, vec, exp_v);
      end
   endtask

   task automatic wait_vec(input logic [6:0] v);
      do @(negedge clk); while (vec !== v);
   endtask

   task automatic frame_burst(input int nfr, input int period);
      repeat (2) @(negedge clk);
      for (int k = 0; k < nfr; k++) begin
         frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
         if (k != nfr - 1) repeat (period - 1) @(negedge clk);
      end
   endtask

   // monitor: closes a segment whenever the output vector changes
   initial begin
      bit first = 1'b1;
      forever begin
         @(negedge clk);
         if (mon_go) begin
            if (first) begin
               last_v = vec; seg_len = 1; first = 1'b0;
            end else if (vec !== last_v) begin
               close_seg(last_v, seg_len);
               last_v = vec; seg_len = 1;
            end else begin
               seg_len++;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL R2 watchdog expired state=%b expected sequence end", vec);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; en_req = 1'b0; frame_start = 1'b0;
      repeat (4) @(negedge clk);
      check_now(V_OFF, "R1");
      rst = 1'b0;
      @(posedge clk);
      mon_go = 1'b1;
      expect_seg(V_OFF, 0, "R1");

      // full up, down with early frame pulse, request re-raised during power-down
      expect_up();
      expect_seg(V_IMG,  6,  "R6");
      expect_seg(V_LOCK, 13, "R7");
      expect_seg(V_VBLK, 63, "R8");
      expect_seg(V_PWR,  1,  "R8");
      expect_seg(V_OFF,  1,  "R10");
      expect_up();
      expect_seg(V_IMG,  6,  "R6");
      expect_seg(V_LOCK, 11, "R7");
      expect_seg(V_VBLK, 63, "R8");
      expect_seg(V_PWR,  1,  "R8");
      expect_seg(V_OFF,  0,  "R1");
      @(negedge clk);
      en_req = 1'b1;
      wait_vec(V_ON);
      repeat (4) @(negedge clk);
      en_req = 1'b0;
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      wait_vec(V_LOCK);
      frame_burst(3, 5);
      wait_vec(V_VBLK);
      en_req = 1'b1;
      wait_vec(V_ON);
      repeat (3) @(negedge clk);
      en_req = 1'b0;
      wait_vec(V_LOCK);
      frame_burst(3, 4);
      wait_vec(V_OFF);

      // R9: withdraw during ramp
      expect_seg(V_PWR, 4, "R9");
      expect_seg(V_OFF, 0, "R1");
      @(negedge clk);
      en_req = 1'b1;
      repeat (3) @(negedge clk);
      en_req = 1'b0;
      wait_vec(V_OFF);
      repeat (5) @(negedge clk);

      // R9: withdraw during video-with-black
      expect_seg(V_PWR,  9,  "R3");
      expect_seg(V_VBLK, 64, "R9");
      expect_seg(V_PWR,  1,  "R8");
      expect_seg(V_OFF,  0,  "R1");
      en_req = 1'b1;
      wait_vec(V_VBLK);
      en_req = 1'b0;
      wait_vec(V_OFF);
      repeat (5) @(negedge clk);

      // R9: withdraw during image lead
      expect_seg(V_PWR,  9,  "R3");
      expect_seg(V_VBLK, 2,  "R2");
      expect_seg(V_LOCK, 11, "R4");
      expect_seg(V_IMG,  1,  "R9");
      expect_seg(V_LOCK, 13, "R9");
      expect_seg(V_VBLK, 63, "R8");
      expect_seg(V_PWR,  1,  "R8");
      expect_seg(V_OFF,  0,  "R1");
      en_req = 1'b1;
      wait_vec(V_IMG);
      en_req = 1'b0;
      wait_vec(V_LOCK);
      frame_burst(3, 5);
      wait_vec(V_OFF);
      repeat (5) @(negedge clk);

      // R1: synchronous reset while fully on
      expect_up();
      expect_seg(V_OFF, 0, "R1");
      en_req = 1'b1;
      wait_vec(V_ON);
      repeat (2) @(negedge clk);
      rst = 1'b1; en_req = 1'b0;
      @(negedge clk);
      check_now(V_OFF, "R1");
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      check_now(V_OFF, "R1");

      tests++;
      if (q_vec.size() != 1 || last_v !== V_OFF) begin
         fails++;
         $display("FAIL R1 final idle left=%0d vec=%b expected left=1 vec=%b",
                  q_vec.size(), last_v, V_OFF);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule